// File: doc/BRIEF.md
# Seconds Counter Alarm Timer

This block is a real-time-clock peripheral built around a free-running 32-bit seconds counter. A prescaler divides the system clock down to a once-per-second tick, and each tick advances the counter by one. Software reaches the block through a plain 32-bit register bus with a word index. Through it, software loads a start count, reads the running count, sets a match value, and controls the enables.

When a tick carries the counter onto the match value, the block latches a raw alarm status. The interrupt line carries that status only while interrupt enable is set and interrupt mask is clear. Software can read both the raw and the gated status. It acknowledges the alarm by reading a dedicated end-of-interrupt word. A write to that word does nothing.

The bus is single-cycle. Writes take effect on the clock edge where `busSel` and `busWr` are both high. Read data is combinational from the word index and the current state.

Top module: `alarmRtc`

## Requirements
- R1: After reset the counter, match, load and control registers read 0, both status bits read 0 and `alarmIrq` is low. Word 7 always reads the `VERSION` parameter.
- R2: A write to word 2 sets the counter to the written value on that edge and restarts the prescaler. Word 2 then reads back the written value.
- R3: While control bit 2 is set, the counter advances by one on every `TICK_DIV`-th edge, counting from the edge that set the bit. While control bit 2 is clear, the counter does not change except by a load.
- R4: When a tick arrives with the counter at 2^32-1, the counter goes to 0 if control bit 3 is set and stays at 2^32-1 if it is clear.
- R5: A tick whose resulting count equals the match register (word 1) sets the raw status, read at word 5 bit 0, whatever the state of control bits 0 and 1. A load that lands on the match value does not set it.
- R6: `alarmIrq` and word 4 bit 0 are high exactly when the raw status is set, control bit 0 (interrupt enable) is set and control bit 1 (interrupt mask) is clear.
- R7: A read of word 6 clears the raw status on that edge and returns 0.
- R8: When a match event and a word-6 read fall in the same cycle, the raw status stays set.
- R9: Word 3 reads back bits 3:0 exactly as last written, with all upper bits 0. Word 1 reads back the full written value.
- R10: Writes to words 0, 4, 5, 6 and 7 change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe for this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busWordAddr | input | 3 | Word index (byte offset divided by 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed word |
| alarmIrq | output | 1 | Gated alarm interrupt |

## Verification
The two functions that can coincide are the setting of the alarm by a tick and its clearing by an end-of-interrupt read. To make them meet, the counter is parked at its maximum with wrap off and the match set to that maximum, so every tick raises a fresh event. Word 6 is then read continuously for twenty cycles. With the interrupt enabled, `alarmIrq` must be high in exactly one cycle after each tick, five in all. If the acknowledge wins the tie, the line never rises. A per-clock behavioural model also checks every read and the interrupt line during the whole run.

// File: rtl/alarmRtcPkg.sv
package alarmRtcPkg;

  // Word index of each register
  typedef enum logic [2:0] {
    REG_COUNT = 3'd0,
    REG_MATCH = 3'd1,
    REG_LOAD  = 3'd2,
    REG_CTRL  = 3'd3,
    REG_MSTAT = 3'd4,
    REG_RSTAT = 3'd5,
    REG_ACK   = 3'd6,
    REG_VER   = 3'd7
  } regSel_e;

  // Control register bit positions
  localparam int CTRL_IE   = 0;
  localparam int CTRL_MASK = 1;
  localparam int CTRL_RUN  = 2;
  localparam int CTRL_WRAP = 3;
  localparam int CTRL_W    = 4;

  // Strobes from the register decoder to the datapath
  typedef struct packed {
    logic loadStb;
    logic ackStb;
  } rtcStrobe_t;

endpackage

// File: rtl/alarmRtcData.sv
module alarmRtcData
  import alarmRtcPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TICK_DIV = 32768
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              runEn,
  input  logic              wrapEn,
  input  logic [DATA_W-1:0] matchVal,
  output logic [DATA_W-1:0] cntVal,
  output logic              rawPend
);

  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  logic              tick;
  logic [DATA_W-1:0] cntInc;
  logic              matchHit;

  // Prescaler: a divide of one needs no counter at all
  generate
    if (TICK_DIV <= 1) begin : gNoPresc
      assign tick = runEn;
    end else begin : gPresc
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] PRESC_LAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] presc;

      assign tick = runEn && (presc == PRESC_LAST);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          presc <= '0;
        end else if (strobe.loadStb || !runEn || tick) begin
          presc <= '0;
        end else begin
          presc <= presc + 1'b1;
        end
      end
    end
  endgenerate

  // Next count on a tick, with saturate or roll at the top
  always_comb begin
    if (cntVal == CNT_MAX) begin
      cntInc = wrapEn ? '0 : CNT_MAX;
    end else begin
      cntInc = cntVal + 1'b1;
    end
  end

  assign matchHit = tick && !strobe.loadStb && (cntInc == matchVal);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal <= '0;
    end else if (strobe.loadStb) begin
      cntVal <= busWdata;
    end else if (tick) begin
      cntVal <= cntInc;
    end
  end

  // A fresh event outranks the acknowledge read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawPend <= 1'b0;
    end else if (matchHit) begin
      rawPend <= 1'b1;
    end else if (strobe.ackStb) begin
      rawPend <= 1'b0;
    end
  end

  // R2: a load lands on the very next edge
  a_r2_load_lands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadStb |=> cntVal == $past(busWdata));

  // R3: a stopped counter only moves by load
  a_r3_stopped_still: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !strobe.loadStb) |=> $stable(cntVal));

  // R4: without wrap the top value is sticky
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal == CNT_MAX && !wrapEn && !strobe.loadStb) |=> cntVal == CNT_MAX);

  // R5: raw status rises only when the count arrives on the match value
  a_r5_rise_on_match: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rawPend) && $stable(matchVal)) |-> cntVal == matchVal);

  // R8: raw status stays until acknowledged
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rawPend && !strobe.ackStb) |=> rawPend);

endmodule

// File: rtl/alarmRtcCtrl.sv
module alarmRtcCtrl
  import alarmRtcPkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] VERSION = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [2:0]        busWordAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] cntVal,
  input  logic              rawPend,
  output logic [DATA_W-1:0] busRdata,
  output rtcStrobe_t        strobe,
  output logic              runEn,
  output logic              wrapEn,
  output logic [DATA_W-1:0] matchVal,
  output logic              alarmIrq
);

  regSel_e           regIdx;
  logic              wrEn;
  logic              rdEn;
  logic [CTRL_W-1:0] ctrlReg;
  logic [DATA_W-1:0] loadReg;

  assign regIdx = regSel_e'(busWordAddr);
  assign wrEn   = busSel && busWr;
  assign rdEn   = busSel && !busWr;

  assign strobe.loadStb = wrEn && (regIdx == REG_LOAD);
  assign strobe.ackStb  = rdEn && (regIdx == REG_ACK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      matchVal <= '0;
      loadReg  <= '0;
    end else if (wrEn) begin
      case (regIdx)
        REG_CTRL:  ctrlReg  <= busWdata[CTRL_W-1:0];
        REG_MATCH: matchVal <= busWdata;
        REG_LOAD:  loadReg  <= busWdata;
        default: ;
      endcase
    end
  end

  assign runEn    = ctrlReg[CTRL_RUN];
  assign wrapEn   = ctrlReg[CTRL_WRAP];
  assign alarmIrq = rawPend && ctrlReg[CTRL_IE] && !ctrlReg[CTRL_MASK];

  always_comb begin
    busRdata = '0;
    case (regIdx)
      REG_COUNT: busRdata = cntVal;
      REG_MATCH: busRdata = matchVal;
      REG_LOAD:  busRdata = loadReg;
      REG_CTRL:  busRdata = {{(DATA_W-CTRL_W){1'b0}}, ctrlReg};
      REG_MSTAT: busRdata = {{(DATA_W-1){1'b0}}, alarmIrq};
      REG_RSTAT: busRdata = {{(DATA_W-1){1'b0}}, rawPend};
      REG_VER:   busRdata = VERSION;
      default:   busRdata = '0;
    endcase
  end

  // R9: control holds unless written at its own word
  a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regIdx == REG_CTRL) |=> $stable(ctrlReg));

  // R10: match only changes through its own word
  a_r10_match_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && regIdx == REG_MATCH) |=> $stable(matchVal));

  // R7: the acknowledge read returns zero data
  a_r7_ack_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ackStb |-> busRdata == '0);

endmodule

// File: rtl/alarmRtc.sv
module alarmRtc
  import alarmRtcPkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                TICK_DIV = 32768,
  parameter logic [DATA_W-1:0] VERSION  = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [2:0]        busWordAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              alarmIrq
);

  rtcStrobe_t        strobe;
  logic              runEn;
  logic              wrapEn;
  logic [DATA_W-1:0] matchVal;
  logic [DATA_W-1:0] cntVal;
  logic              rawPend;

  alarmRtcCtrl #(.DATA_W(DATA_W), .VERSION(VERSION)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .cntVal(cntVal),
    .rawPend(rawPend), .busRdata(busRdata), .strobe(strobe), .runEn(runEn),
    .wrapEn(wrapEn), .matchVal(matchVal), .alarmIrq(alarmIrq)
  );

  alarmRtcData #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .runEn(runEn), .wrapEn(wrapEn), .matchVal(matchVal), .cntVal(cntVal),
    .rawPend(rawPend)
  );

  // R6: the line never rises while masked
  a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busWordAddr == 3'd3 && busWdata[1]) |=> !alarmIrq);

endmodule

// File: tb/alarmRtc_test.sv
module alarmRtc_test;

  localparam int          DIV = 4;
  localparam logic [31:0] VER = 32'h0001_0200;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [2:0]  busWordAddr = 3'd0;
  logic [31:0] busWdata = 32'd0;
  logic [31:0] busRdata;
  logic        alarmIrq;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";

  // reference model state
  logic [31:0] mCnt = 0, mMatch = 0, mLoad = 0;
  logic [3:0]  mCtrl = 0;
  int          mPresc = 0;
  bit          mRaw = 0;

  alarmRtc #(.DATA_W(32), .TICK_DIV(DIV), .VERSION(VER)) uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busWordAddr(busWordAddr), .busWdata(busWdata), .busRdata(busRdata),
    .alarmIrq(alarmIrq)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [2:0] a);
    bit irq;
    irq = mRaw && mCtrl[0] && !mCtrl[1];
    case (a)
      3'd0: return mCnt;
      3'd1: return mMatch;
      3'd2: return mLoad;
      3'd3: return {28'd0, mCtrl};
      3'd4: return {31'd0, irq};
      3'd5: return {31'd0, mRaw};
      3'd7: return VER;
      default: return 32'd0;
    endcase
  endfunction

  // behavioural model, advanced on every edge and compared shortly after
  always @(posedge clk) begin
    logic [2:0]  a;
    logic [31:0] nc;
    bit w, r, tk, ld, ev;
    a  = busWordAddr;
    w  = busSel && busWr;
    r  = busSel && !busWr;
    if (!rstN) begin
      mCnt = 0; mMatch = 0; mLoad = 0; mCtrl = 0; mPresc = 0; mRaw = 0;
    end else begin
      tk = mCtrl[2] && (mPresc == DIV - 1);
      ld = w && (a == 3'd2);
      ev = 0;
      nc = mCnt;
      if (ld) nc = busWdata;
      else if (tk) begin
        if (mCnt == 32'hFFFF_FFFF) nc = mCtrl[3] ? 32'd0 : mCnt;
        else nc = mCnt + 1;
        ev = (nc == mMatch);
      end
      mPresc = (ld || !mCtrl[2] || tk) ? 0 : mPresc + 1;
      if (ev) mRaw = 1;
      else if (r && a == 3'd6) mRaw = 0;
      mCnt = nc;
      if (w && a == 3'd1) mMatch = busWdata;
      if (ld) mLoad = busWdata;
      if (w && a == 3'd3) mCtrl = busWdata[3:0];
    end
    #2;
    if (rstN) begin
      check({curReq, " irq line"}, {31'd0, alarmIrq}, {31'd0, mRaw && mCtrl[0] && !mCtrl[1]});
      if (busSel && !busWr) check({curReq, " read data"}, busRdata, modelRead(busWordAddr));
    end
  end

  // Called at a negedge; returns at the negedge after the access edge
  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    busSel = 1; busWr = 1; busWordAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    busSel = 1; busWr = 0; busWordAddr = a;
    #2 d = busRdata;
    @(negedge clk);
    busSel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int hits;
    idle(3);
    rstN = 1;

    // R1: reset state
    curReq = "R1";
    busRead(3'd7, d); check("R1 version", d, VER);
    busRead(3'd0, d); check("R1 count", d, 0);
    busRead(3'd3, d); check("R1 control", d, 0);
    busRead(3'd5, d); check("R1 raw status", d, 0);
    check("R1 irq", {31'd0, alarmIrq}, 0);

    // R9: readback
    curReq = "R9";
    busWrite(3'd3, 32'hFFFF_FFFB);
    busRead(3'd3, d); check("R9 control readback", d, 32'hB);
    busWrite(3'd3, 32'h0);
    busWrite(3'd1, 32'hA5A5_0001);
    busRead(3'd1, d); check("R9 match readback", d, 32'hA5A5_0001);
    idle(2);

    // R2: load
    curReq = "R2";
    busWrite(3'd2, 32'h100);
    busRead(3'd2, d); check("R2 load readback", d, 32'h100);
    busRead(3'd0, d); check("R2 count loaded", d, 32'h100);

    // R3: advance then stall
    curReq = "R3";
    busWrite(3'd3, 32'h4);
    idle(38);
    busWrite(3'd3, 32'h0);
    busRead(3'd0, d); check("R3 nine ticks", d, 32'h109);
    idle(10);
    busRead(3'd0, d); check("R3 stopped", d, 32'h109);

    // R5 / R6: match with mask, then enable
    curReq = "R5";
    busWrite(3'd1, 32'h10C);
    busWrite(3'd3, 32'h6);
    idle(20);
    busRead(3'd5, d); check("R5 raw set while masked", d, 1);
    curReq = "R6";
    busRead(3'd4, d); check("R6 masked status low", d, 0);
    check("R6 irq masked", {31'd0, alarmIrq}, 0);
    busWrite(3'd3, 32'h5);
    check("R6 irq enabled", {31'd0, alarmIrq}, 1);
    busRead(3'd4, d); check("R6 masked status high", d, 1);
    busWrite(3'd3, 32'h4);
    check("R6 irq disabled", {31'd0, alarmIrq}, 0);

    // R7: acknowledge read
    curReq = "R7";
    busRead(3'd6, d); check("R7 ack data", d, 0);
    busRead(3'd5, d); check("R7 raw cleared", d, 0);
    busWrite(3'd3, 32'h0);
    idle(2);

    // R8: events coincide with held acknowledge reads
    curReq = "R8";
    busWrite(3'd2, 32'hFFFF_FFFD);
    busWrite(3'd1, 32'hFFFF_FFFF);
    busWrite(3'd3, 32'h5);
    idle(12);
    hits = 0;
    busSel = 1; busWr = 0; busWordAddr = 3'd6;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (alarmIrq) hits++;
    end
    busSel = 0;
    check("R8 event beats ack", hits, 5);

    // R4: saturate then wrap
    curReq = "R4";
    busWrite(3'd3, 32'h0);
    busRead(3'd0, d); check("R4 held at top", d, 32'hFFFF_FFFF);
    busRead(3'd6, d);
    busWrite(3'd3, 32'hC);
    idle(6);
    busWrite(3'd3, 32'h0);
    busRead(3'd0, d); check("R4 rolled to zero", d, 0);
    busRead(3'd5, d); check("R4 no event at roll", d, 0);

    // R10: writes to read-only words
    curReq = "R10";
    busWrite(3'd0, 32'h1234_5678);
    busRead(3'd0, d); check("R10 count untouched", d, 0);
    busWrite(3'd7, 32'h0);
    busRead(3'd7, d); check("R10 version untouched", d, VER);
    busWrite(3'd5, 32'h1);
    busRead(3'd5, d); check("R10 raw untouched", d, 0);
    busWrite(3'd4, 32'h1);
    busRead(3'd4, d); check("R10 masked untouched", d, 0);
    busWrite(3'd6, 32'hFFFF_FFFF);
    busRead(3'd3, d); check("R10 control untouched", d, 0);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule